// File: doc/BRIEF.md
# Signed Integer to Double Converter

This block turns a signed 64-bit two's-complement integer into an IEEE 754 double-precision number. The integer is taken from the low doubleword of a 128-bit source register value. The rounded result is returned in the low doubleword of a 128-bit destination value, and the high doubleword is always forced to zero. Next to the result the block reports three things: whether rounding increased the significand's magnitude, whether the result is inexact, and a 5-bit code that classifies the result. A sticky inexact flag collects inexact events across conversions until it is cleared on purpose.

A conversion starts on a cycle where `in_valid` is high and `unit_en` is high, and its results appear one cycle later together with `out_valid`. If `in_valid` arrives while `unit_en` is low, nothing is converted. The block pulses `unavail` one cycle later and leaves the result and all flags untouched. The rounding mode is sampled with each request.

Top module: `i2d_convert`

## Requirements
- R1: For an accepted request, `dst[63:0]` holds the double-precision value of `src[63:0]` read as signed two's complement (for example 1 gives 64'h3FF0000000000000).
- R2: `rmode` selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R3: `dst[127:64]` is all zeros at all times.
- R4: `frac_rounded` is 1 after a conversion exactly when rounding added one unit to the truncated 53-bit significand, and 0 otherwise.
- R5: `frac_inexact` is 1 after a conversion exactly when the result differs from the integer. Magnitudes up to 2^53 are always exact, and -2^63 converts exactly to 64'hC3E0000000000000.
- R6: `sticky_inexact` is set by any inexact conversion and stays set. A cycle with `sticky_clr` high clears it on the next edge, except that an inexact conversion accepted in the same cycle keeps it set.
- R7: `res_class` is 5'b00010 for +0.0, 5'b00100 for a positive result and 5'b01000 for a negative result.
- R8: A request with `unit_en` low gives `unavail` = 1 on the next cycle. It leaves `out_valid` at 0, and `dst`, `frac_rounded`, `frac_inexact` and `res_class` unchanged.
- R9: Outputs are registered. `out_valid` is high exactly in the cycle after an accepted request. After reset every output is 0.
- R10: When rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero (2^63-1 rounded to nearest gives 64'h43E0000000000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request strobe |
| unit_en | input | 1 | Unit enable; a request while low is refused |
| rmode | input | 2 | Rounding mode for the request |
| src | input | 128 | Source register value; integer in bits 63:0 |
| sticky_clr | input | 1 | Clears the sticky inexact flag |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| dst | output | 128 | Destination value; double in bits 63:0, zeros above |
| frac_rounded | output | 1 | Significand was incremented by rounding |
| frac_inexact | output | 1 | Result is not exact |
| sticky_inexact | output | 1 | Accumulated inexact flag |
| res_class | output | 5 | Result class code |
| unavail | output | 1 | Previous cycle's request was refused |

## Verification
The assertions assume that the bits of `src` above bit 63 have no effect, and that `rmode` is only meaningful on request cycles. The stimulus therefore fills the high doubleword with random values and changes the mode freely between requests. The hold and clear properties of the sticky flag assume that `sticky_clr` may coincide with a conversion. The stimulus makes that collision happen on purpose, and it also issues refused requests between accepted ones, so that each held output is checked against the state it had before.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
  localparam int INT_W   = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int BIAS    = 1023;
  localparam int LZ_W    = $clog2(INT_W);
  localparam int LOW_W   = INT_W - SIG_W;   // bits below the significand
  localparam int CLS_W   = 5;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_POS_INF   = 2'b10,
    RND_NEG_INF   = 2'b11
  } rnd_mode_e;

  localparam logic [CLS_W-1:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NEG_NORM = 5'b01000;

  // decide whether the truncated significand is bumped by one unit
  function automatic logic f_round_up(input logic [1:0] mode, input logic neg,
                                      input logic lsb, input logic guard,
                                      input logic sticky);
    logic lost;
    lost = guard | sticky;
    case (rnd_mode_e'(mode))
      RND_NEAR_EVEN: f_round_up = guard & (sticky | lsb);
      RND_ZERO:      f_round_up = 1'b0;
      RND_POS_INF:   f_round_up = ~neg & lost;
      default:       f_round_up = neg & lost;
    endcase
  endfunction

  function automatic logic [CLS_W-1:0] f_class(input logic neg, input logic is_zero);
    if (is_zero)  f_class = CLS_POS_ZERO;
    else if (neg) f_class = CLS_NEG_NORM;
    else          f_class = CLS_POS_NORM;
  endfunction
endpackage

// File: rtl/i2d_lzc.sv
module i2d_lzc #(
  parameter int W   = 64,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          none
);
  // one-hot marker of the leading one, built bit by bit
  logic [W-1:0] above;   // above[i]: some bit higher than i is set
  logic [W-1:0] lead;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_rest
        assign above[i] = above[i+1] | vec[i+1];
      end
      assign lead[i] = vec[i] & ~above[i];
    end
  endgenerate

  always_comb begin
    count = '0;
    for (int k = 0; k < W; k++) begin
      if (lead[k]) count = CW'(W - 1 - k);
    end
  end

  assign none = ~|vec;
endmodule

// File: rtl/i2d_round_core.sv
module i2d_round_core
  import i2d_pkg::*;
(
  input  logic [INT_W-1:0] int_val,
  input  logic [1:0]       mode,
  output logic [INT_W-1:0] result,
  output logic             bumped,
  output logic             lossy,
  output logic             carry_out,
  output logic [CLS_W-1:0] cls
);
  logic             neg;
  logic [INT_W-1:0] mag;
  logic [LZ_W-1:0]  lz;
  logic             is_zero;
  logic [INT_W-1:0] norm;
  logic [SIG_W-1:0] sig;
  logic             guard_b;
  logic             sticky_b;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign neg = int_val[INT_W-1];
  assign mag = neg ? (~int_val + 1'b1) : int_val;

  i2d_lzc #(.W(INT_W)) u_lzc (
    .vec   (mag),
    .count (lz),
    .none  (is_zero)
  );

  assign norm     = mag << lz;
  assign sig      = norm[INT_W-1 -: SIG_W];
  assign guard_b  = norm[LOW_W-1];
  assign sticky_b = |norm[LOW_W-2:0];

  assign bumped    = ~is_zero & f_round_up(mode, neg, sig[0], guard_b, sticky_b);
  assign lossy     = ~is_zero & (guard_b | sticky_b);
  assign sum       = {1'b0, sig} + {{SIG_W{1'b0}}, bumped};
  assign carry_out = sum[SIG_W];

  assign exp_f  = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz) + EXP_W'(carry_out);
  assign frac_f = carry_out ? '0 : sum[FRAC_W-1:0];

  assign result = is_zero ? '0 : {neg, exp_f, frac_f};
  assign cls    = f_class(neg, is_zero);
endmodule

// File: rtl/i2d_convert.sv
module i2d_convert
  import i2d_pkg::*;
#(
  parameter int REG_W = 128,
  localparam int HI_W = REG_W - INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             unit_en,
  input  logic [1:0]       rmode,
  input  logic [REG_W-1:0] src,
  input  logic             sticky_clr,
  output logic             out_valid,
  output logic [REG_W-1:0] dst,
  output logic             frac_rounded,
  output logic             frac_inexact,
  output logic             sticky_inexact,
  output logic [CLS_W-1:0] res_class,
  output logic             unavail
);
  // named events for the checker
  logic             go;
  logic             refused;
  logic             conv_inexact;
  logic             conv_bumped;
  logic             conv_carry;
  logic [INT_W-1:0] conv_res;
  logic [CLS_W-1:0] conv_cls;
  logic [INT_W-1:0] lo_q;

  assign go      = in_valid & unit_en;
  assign refused = in_valid & ~unit_en;

  i2d_round_core u_core (
    .int_val   (src[INT_W-1:0]),
    .mode      (rmode),
    .result    (conv_res),
    .bumped    (conv_bumped),
    .lossy     (conv_inexact),
    .carry_out (conv_carry),
    .cls       (conv_cls)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      unavail        <= 1'b0;
      lo_q           <= '0;
      frac_rounded   <= 1'b0;
      frac_inexact   <= 1'b0;
      res_class      <= '0;
      sticky_inexact <= 1'b0;
    end else begin
      out_valid      <= go;
      unavail        <= refused;
      sticky_inexact <= (sticky_inexact & ~sticky_clr) | (go & conv_inexact);
      if (go) begin
        lo_q         <= conv_res;
        frac_rounded <= conv_bumped;
        frac_inexact <= conv_inexact;
        res_class    <= conv_cls;
      end
    end
  end

  assign dst = {{HI_W{1'b0}}, lo_q};
endmodule

// File: rtl/i2d_checker.sv
module i2d_checker
  import i2d_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             refused,
  input logic             conv_inexact,
  input logic             sticky_clr,
  input logic [127:0]     src,
  input logic             out_valid,
  input logic [127:0]     dst,
  input logic             frac_rounded,
  input logic             frac_inexact,
  input logic             sticky_inexact,
  input logic [CLS_W-1:0] res_class,
  input logic             unavail
);
  logic small_pos;
  assign small_pos = (src[63:53] == 11'd0);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dst[127:64] == 64'd0);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> out_valid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !out_valid);

  assert_refused_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> unavail);

  assert_refused_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> ($stable(dst) && $stable(res_class) && $stable(frac_inexact)
                 && $stable(frac_rounded)));

  assert_bump_needs_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && frac_rounded) |-> frac_inexact);

  assert_small_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && small_pos) |=> !frac_inexact);

  assert_sticky_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && conv_inexact) |=> sticky_inexact);

  assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_inexact && !sticky_clr) |=> sticky_inexact);

  assert_sticky_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !(go && conv_inexact)) |=> !sticky_inexact);

  assert_class_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(res_class) == 1));

  assert_zero_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dst[63:0] == 64'd0) |-> (res_class == CLS_POS_ZERO));
endmodule

bind i2d_convert i2d_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .go             (go),
  .refused        (refused),
  .conv_inexact   (conv_inexact),
  .sticky_clr     (sticky_clr),
  .src            (src),
  .out_valid      (out_valid),
  .dst            (dst),
  .frac_rounded   (frac_rounded),
  .frac_inexact   (frac_inexact),
  .sticky_inexact (sticky_inexact),
  .res_class      (res_class),
  .unavail        (unavail)
);

// File: tb/i2d_convert_test.sv
`timescale 1ns/1ps
module i2d_convert_test;
  localparam real PERIOD = 20.0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         unit_en = 1'b0;
  logic [1:0]   rmode = 2'b00;
  logic [127:0] src = '0;
  logic         sticky_clr = 1'b0;
  logic         out_valid;
  logic [127:0] dst;
  logic         frac_rounded;
  logic         frac_inexact;
  logic         sticky_inexact;
  logic [4:0]   res_class;
  logic         unavail;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [63:0] m_lo = '0;
  bit          m_fr = 0, m_fi = 0, m_st = 0, m_ov = 0, m_un = 0;
  logic [4:0]  m_cls = '0;

  always #(PERIOD/2) clk = ~clk;

  i2d_convert uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .unit_en(unit_en),
    .rmode(rmode), .src(src), .sticky_clr(sticky_clr), .out_valid(out_valid),
    .dst(dst), .frac_rounded(frac_rounded), .frac_inexact(frac_inexact),
    .sticky_inexact(sticky_inexact), .res_class(res_class), .unavail(unavail)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // value-based model: find top bit, split quotient and remainder
  task automatic ref_conv(input logic [63:0] x, input logic [1:0] rm,
                          output logic [63:0] res, output bit fr, output bit fi,
                          output logic [4:0] cls);
    bit neg;
    logic [63:0] m, q, rem, half;
    int p;
    bit up;
    neg = x[63];
    m = neg ? (~x + 64'd1) : x;
    if (m == 64'd0) begin
      res = '0; fr = 0; fi = 0; cls = 5'd2;
      return;
    end
    p = 0;
    for (int i = 0; i < 64; i++) if (m[i]) p = i;
    if (p <= 52) begin
      q = m << (52 - p); rem = 0; half = 64'd1;
    end else begin
      q = m >> (p - 52);
      rem = m & ((64'd1 << (p - 52)) - 64'd1);
      half = 64'd1 << (p - 53);
    end
    fi = (rem != 0);
    case (rm)
      2'd0: up = (rem > half) || (rem == half && q[0]);
      2'd1: up = 0;
      2'd2: up = !neg && fi;
      default: up = neg && fi;
    endcase
    q = q + {63'd0, up};
    if (q[53]) begin
      q = q >> 1; p = p + 1;
    end
    res = {neg, 11'(1023 + p), q[51:0]};
    cls = neg ? 5'd8 : 5'd4;
    fr  = up;
  endtask

  // drive one cycle at a negedge, advance the model, compare at the next negedge
  task automatic step(input string tag, input bit v, input bit en, input logic [1:0] rm,
                      input logic [63:0] x, input bit clr);
    logic [63:0] r;
    bit fr, fi;
    logic [4:0] c;
    in_valid = v; unit_en = en; rmode = rm; sticky_clr = clr;
    src = {$urandom(), $urandom(), x};
    ref_conv(x, rm, r, fr, fi, c);
    m_ov = v & en;
    m_un = v & !en;
    m_st = (m_st & !clr) | (v & en & fi);
    if (v && en) begin
      m_lo = r; m_fr = fr; m_fi = fi; m_cls = c;
    end
    @(negedge clk);
    chk({tag, " R1 dst"}, {64'd0, dst[63:0]}, {64'd0, m_lo});
    chk("R3 upper", {64'd0, dst[127:64]}, 128'd0);
    chk("R4 frac_rounded", {127'd0, frac_rounded}, {127'd0, m_fr});
    chk("R5 frac_inexact", {127'd0, frac_inexact}, {127'd0, m_fi});
    chk("R6 sticky", {127'd0, sticky_inexact}, {127'd0, m_st});
    chk("R7 class", {123'd0, res_class}, {123'd0, m_cls});
    chk("R9 out_valid", {127'd0, out_valid}, {127'd0, m_ov});
    chk("R8 unavail", {127'd0, unavail}, {127'd0, m_un});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 reset dst", dst, 128'd0);
    chk("R9 reset flags", {123'd0, out_valid, unavail, frac_rounded, frac_inexact, sticky_inexact},
        128'd0);
    chk("R9 reset class", {123'd0, res_class}, 128'd0);

    step("zero", 1, 1, 2'd0, 64'd0, 0);
    chk("R7 zero class", {123'd0, res_class}, 128'd2);
    step("one", 1, 1, 2'd0, 64'd1, 0);
    chk("R1 one", {64'd0, dst[63:0]}, {64'd0, 64'h3FF0000000000000});
    step("minus one", 1, 1, 2'd0, 64'hFFFFFFFFFFFFFFFF, 0);
    chk("R1 minus one", {64'd0, dst[63:0]}, {64'd0, 64'hBFF0000000000000});
    step("two pow 53", 1, 1, 2'd2, 64'h0020000000000000, 0);
    chk("R5 2^53 exact", {127'd0, frac_inexact}, 128'd0);
    step("min int", 1, 1, 2'd3, 64'h8000000000000000, 0);
    chk("R5 min int", {64'd0, dst[63:0]}, {64'd0, 64'hC3E0000000000000});
    chk("R5 min int exact", {127'd0, frac_inexact}, 128'd0);
    for (int md = 0; md < 4; md++) begin
      // R2 ties: 2^53+1 (lsb even), 2^53+3 (lsb odd), negative tie
      step("R2 tie even", 1, 1, 2'(md), 64'h0020000000000001, 0);
      step("R2 tie odd", 1, 1, 2'(md), 64'h0020000000000003, 0);
      step("R2 neg tie", 1, 1, 2'(md), 64'hFFDFFFFFFFFFFFFD, 0);
      step("R10 max", 1, 1, 2'(md), 64'h7FFFFFFFFFFFFFFF, 0);
    end
    step("R10 max near", 1, 1, 2'd0, 64'h7FFFFFFFFFFFFFFF, 0);
    chk("R10 carry", {64'd0, dst[63:0]}, {64'd0, 64'h43E0000000000000});
    // R8 refused request must not disturb the held result
    step("R8 refused", 1, 0, 2'd1, 64'h0000000000001234, 0);
    chk("R8 held", {64'd0, dst[63:0]}, {64'd0, 64'h43E0000000000000});
    // R6 clear, then clear colliding with an inexact conversion
    step("R6 clear", 0, 1, 2'd0, 64'd5, 1);
    chk("R6 cleared", {127'd0, sticky_inexact}, 128'd0);
    step("R6 clr+set", 1, 1, 2'd1, 64'h7FFFFFFFFFFFFFFF, 1);
    chk("R6 set wins", {127'd0, sticky_inexact}, 128'd1);
    step("R6 idle", 0, 0, 2'd0, 64'd0, 0);
    chk("R6 hold", {127'd0, sticky_inexact}, 128'd1);

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] x;
      int sh;
      sh = $urandom_range(0, 63);
      x = {$urandom(), $urandom()} >> sh;
      if ($urandom_range(0, 1) == 1) x = ~x + 64'd1;
      step("random", $urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0,
           2'($urandom_range(0, 3)), x, $urandom_range(0, 15) == 0);
    end
    summary();
  end
endmodule